// File: doc/BRIEF.md
# Control Link Destination Resolver

This block takes a 16-bit destination control link and resolves it into the context that a control transfer switches to. That context is a local frame, a global frame, a 32-bit code base and a start PC. The low two bits of the link select its kind. A frame link points straight at a local frame, and the new global frame and PC are read from the two overhead words just below that frame. An indirect link is a word address that holds the real link, and the resolver follows it and classifies the result again. A procedure descriptor carries a global-frame-table index and an entry index. The resolver looks up the global frame in the table, loads the code base stored under that global frame, and reads the entry PC from the code segment.

A transfer sequencer pulses `start` with the link, the source link, a return flag and the current global frame and code base. The resolver then issues single-word reads on a simple memory port. Read data arrives on `memRdata` one cycle after `memRd` is asserted. When resolution is complete the resolver pulses `resolveDone` for one cycle, together with the resolved values or a trap kind and trap parameter. Frame allocation, pushing links on a stack and loading the PC into a fetch unit belong to neighbouring blocks.

Top module: `ctrl_link_resolver`

## Requirements
- R1: A nonzero link with bits [1:0]=00 is a frame link F. The resolver reads the global frame from address F-2 and the PC from address F-1, and returns `newLocal`=F.
- R2: For a frame link whose global frame equals `curGlobal`, no read is made below that global frame, and `newCode` equals `curCode`.
- R3: Otherwise the code base is loaded as low word from G-2 and high word from G-1, where G is the new global frame. If that low word is odd, the result is a code trap (`trapKind`=3) with the original destination link as the parameter.
- R4: A link with bit 0 set is a procedure descriptor. Its table index is bits [15:6] and its entry index is bits [5:1]. The table entry is read at `GFT_BASE`+index. The global frame is that entry with bits [1:0] cleared, and `newLocal` is 0.
- R5: The entry PC of a procedure is read at code-base low word + 32*entry[1:0] + entry index + 2.
- R6: A procedure whose table entry yields global frame 0 gives an unbound trap (`trapKind`=2) with the original destination link as the parameter.
- R7: A procedure whose entry PC reads as 0 gives an unbound trap (`trapKind`=2) with the original destination link as the parameter.
- R8: A link with bits [1:0]=10 is the address of a word that holds the next link. That next link is then classified again, so indirect links may chain to any link kind.
- R9: A link equal to 0, whether given directly or reached through an indirect link, gives a control trap (`trapKind`=1). Its parameter is `srcLink`, or 0 when `isReturn` is set. A successful resolution reports `trapKind`=0.
- R10: At most `MAX_INDIRECT` indirect links are followed. Reaching a further indirect link gives a control trap with the parameter defined in R9.
- R11: `resolveDone` is high for exactly one cycle. All result outputs hold their values from then until the next accepted `start`. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a resolution; accepted only when idle |
| destLink | input | 16 | Destination control link |
| srcLink | input | 16 | Source control link, used as the control trap parameter |
| isReturn | input | 1 | Transfer is a return; the control trap parameter becomes 0 |
| curGlobal | input | 16 | Global frame of the current context |
| curCode | input | 32 | Code base of the current context |
| memRd | output | 1 | Word read request |
| memAddr | output | 16 | Word read address |
| memRdata | input | 16 | Read data, valid the cycle after `memRd` |
| busy | output | 1 | Resolution in progress |
| resolveDone | output | 1 | One-cycle completion strobe |
| trapKind | output | 2 | 0 none, 1 control, 2 unbound, 3 code |
| trapParam | output | 16 | Trap parameter |
| newLocal | output | 16 | Resolved local frame (0 for a procedure) |
| newGlobal | output | 16 | Resolved global frame |
| newCode | output | 32 | Resolved code base |
| newPc | output | 16 | Resolved start PC |

## Verification
Frame links are applied twice: once with a global frame equal to the current one and once with a different one. Counting reads at the code-base addresses shows whether the reload was skipped. Procedure descriptors are applied with a nonzero bias and with both values of link bit 1, which checks field extraction and the entry address sum. Separate descriptors return a zero global frame or a zero PC, so each unbound cause is seen on its own. Indirect chains of one, two, exactly `MAX_INDIRECT` and `MAX_INDIRECT`+1 hops, plus a chain that ends in a zero link, separate correct following from the limit, and a zero link is tried both with and without the return flag. A `start` pulse during a resolution and input changes after completion show that results are held.

// File: rtl/clr_pkg.sv
package clr_pkg;

  typedef enum logic [1:0] {
    TRAP_NONE    = 2'd0,
    TRAP_CONTROL = 2'd1,
    TRAP_UNBOUND = 2'd2,
    TRAP_CODE    = 2'd3
  } trap_e;

  typedef enum logic [2:0] {
    A_LINK,
    A_FGLOBAL,
    A_FPC,
    A_GFT,
    A_CBLO,
    A_CBHI,
    A_ENTRY
  } addr_sel_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DISP,
    S_INDCAP,
    S_FPC,
    S_FCHK,
    S_GCAP,
    S_CBLO,
    S_CBHI,
    S_CBEND,
    S_PCRD,
    S_PCCAP,
    S_DONE
  } state_e;

  typedef struct packed {
    logic  ldStart;
    logic  ldLink;
    logic  ldFrameGf;
    logic  ldEntryGf;
    logic  ldPc;
    logic  ldCbLo;
    logic  ldCbHi;
    logic  keepCb;
    logic  setTrap;
    trap_e trapSel;
  } strobe_t;

  typedef struct packed {
    logic       linkZero;
    logic [1:0] linkTag;
    logic       depthFull;
    logic       rdZero;
    logic       rdGfZero;
    logic       gfSame;
    logic       cbLoOdd;
  } status_t;

endpackage

// File: rtl/clr_datapath.sv
module clr_datapath
  import clr_pkg::*;
#(
  parameter logic [15:0] GFT_BASE     = 16'h0400,
  parameter int          MAX_INDIRECT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  strobe_t     stb,
  input  addr_sel_e   addrSel,
  input  logic        busy,
  input  logic        doneIn,
  input  logic        start,
  input  logic [15:0] destLink,
  input  logic [15:0] srcLink,
  input  logic        isReturn,
  input  logic [15:0] curGlobal,
  input  logic [31:0] curCode,
  input  logic [15:0] memRdata,
  output logic [15:0] memAddr,
  output status_t     status,
  output trap_e       trapKind,
  output logic [15:0] trapParam,
  output logic [15:0] newLocal,
  output logic [15:0] newGlobal,
  output logic [31:0] newCode,
  output logic [15:0] newPc
);

  localparam int DW = $clog2(MAX_INDIRECT + 1);

  logic [15:0] linkQ, destQ, srcQ, curGfQ, cbLoQ, gfQ, pcQ, lfQ, paramQ;
  logic [31:0] curCbQ, cbQ;
  logic        retQ;
  logic [1:0]  biasQ;
  logic [DW-1:0] depthQ;
  trap_e       trapQ;

  logic [15:0] gftIndex, entryOff;
  assign gftIndex = {6'b0, linkQ[15:6]};
  assign entryOff = {9'b0, biasQ, 5'b0} + {11'b0, linkQ[5:1]} + 16'd2;

  always_comb begin
    case (addrSel)
      A_LINK:    memAddr = linkQ;
      A_FGLOBAL: memAddr = linkQ - 16'd2;
      A_FPC:     memAddr = linkQ - 16'd1;
      A_GFT:     memAddr = GFT_BASE + gftIndex;
      A_CBLO:    memAddr = gfQ - 16'd2;
      A_CBHI:    memAddr = gfQ - 16'd1;
      A_ENTRY:   memAddr = cbQ[15:0] + entryOff;
      default:   memAddr = linkQ;
    endcase
  end

  assign status.linkZero  = (linkQ == 16'd0);
  assign status.linkTag   = linkQ[1:0];
  assign status.depthFull = (depthQ == DW'(MAX_INDIRECT));
  assign status.rdZero    = (memRdata == 16'd0);
  assign status.rdGfZero  = (memRdata[15:2] == 14'd0);
  assign status.gfSame    = (gfQ == curGfQ);
  assign status.cbLoOdd   = cbLoQ[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linkQ  <= '0; destQ <= '0; srcQ <= '0; curGfQ <= '0; curCbQ <= '0;
      retQ   <= 1'b0; depthQ <= '0; biasQ <= '0; cbLoQ <= '0;
      gfQ    <= '0; pcQ <= '0; cbQ <= '0; lfQ <= '0;
      trapQ  <= TRAP_NONE; paramQ <= '0;
    end else begin
      if (stb.ldStart) begin
        linkQ  <= destLink;
        destQ  <= destLink;
        srcQ   <= srcLink;
        retQ   <= isReturn;
        curGfQ <= curGlobal;
        curCbQ <= curCode;
        depthQ <= '0;
        trapQ  <= TRAP_NONE;
        paramQ <= '0;
      end
      if (stb.ldLink) begin
        linkQ  <= memRdata;
        depthQ <= depthQ + DW'(1);
      end
      if (stb.ldFrameGf) begin
        gfQ   <= memRdata;
        lfQ   <= linkQ;
        biasQ <= 2'd0;
      end
      if (stb.ldEntryGf) begin
        gfQ   <= {memRdata[15:2], 2'b00};
        biasQ <= memRdata[1:0];
        lfQ   <= 16'd0;
      end
      if (stb.ldPc)   pcQ   <= memRdata;
      if (stb.keepCb) cbQ   <= curCbQ;
      if (stb.ldCbLo) cbLoQ <= memRdata;
      if (stb.ldCbHi) cbQ   <= {memRdata, cbLoQ};
      if (stb.setTrap) begin
        trapQ  <= stb.trapSel;
        paramQ <= (stb.trapSel == TRAP_CONTROL) ? (retQ ? 16'd0 : srcQ) : destQ;
      end
    end
  end

  assign trapKind  = trapQ;
  assign trapParam = paramQ;
  assign newLocal  = lfQ;
  assign newGlobal = gfQ;
  assign newCode   = cbQ;
  assign newPc     = pcQ;

  // R10
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depthQ <= DW'(MAX_INDIRECT));

  // R11
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({trapQ, paramQ, lfQ, gfQ, cbQ, pcQ}));

  // R9
  ctl_trap_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIn && trapQ == TRAP_CONTROL) |-> (paramQ == (retQ ? 16'd0 : srcQ)));

  // R3
  code_trap_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneIn && trapQ == TRAP_CODE) |-> (paramQ == destQ));

endmodule

// File: rtl/clr_control.sv
module clr_control
  import clr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  status_t   status,
  output strobe_t   stb,
  output addr_sel_e addrSel,
  output logic      memRd,
  output logic      busy,
  output logic      resolveDone
);

  state_e stateQ, stateD;
  logic   isProcQ, isProcD;

  always_comb begin
    stb     = '0;
    addrSel = A_LINK;
    memRd   = 1'b0;
    stateD  = stateQ;
    isProcD = isProcQ;
    case (stateQ)
      S_IDLE: if (start) begin
        stb.ldStart = 1'b1;
        stateD      = S_DISP;
      end
      S_DISP: begin
        if (status.linkZero) begin
          stb.setTrap = 1'b1; stb.trapSel = TRAP_CONTROL; stateD = S_DONE;
        end else if (status.linkTag[0]) begin
          memRd = 1'b1; addrSel = A_GFT; isProcD = 1'b1; stateD = S_GCAP;
        end else if (!status.linkTag[1]) begin
          memRd = 1'b1; addrSel = A_FGLOBAL; isProcD = 1'b0; stateD = S_FPC;
        end else if (status.depthFull) begin
          stb.setTrap = 1'b1; stb.trapSel = TRAP_CONTROL; stateD = S_DONE;
        end else begin
          memRd = 1'b1; addrSel = A_LINK; stateD = S_INDCAP;
        end
      end
      S_INDCAP: begin
        stb.ldLink = 1'b1; stateD = S_DISP;
      end
      S_FPC: begin
        stb.ldFrameGf = 1'b1; memRd = 1'b1; addrSel = A_FPC; stateD = S_FCHK;
      end
      S_FCHK: begin
        stb.ldPc = 1'b1;
        if (status.gfSame) begin
          stb.keepCb = 1'b1; stateD = S_DONE;
        end else begin
          stateD = S_CBLO;
        end
      end
      S_GCAP: begin
        stb.ldEntryGf = 1'b1;
        if (status.rdGfZero) begin
          stb.setTrap = 1'b1; stb.trapSel = TRAP_UNBOUND; stateD = S_DONE;
        end else begin
          stateD = S_CBLO;
        end
      end
      S_CBLO: begin
        memRd = 1'b1; addrSel = A_CBLO; stateD = S_CBHI;
      end
      S_CBHI: begin
        stb.ldCbLo = 1'b1; memRd = 1'b1; addrSel = A_CBHI; stateD = S_CBEND;
      end
      S_CBEND: begin
        stb.ldCbHi = 1'b1;
        if (status.cbLoOdd) begin
          stb.setTrap = 1'b1; stb.trapSel = TRAP_CODE; stateD = S_DONE;
        end else if (isProcQ) begin
          stateD = S_PCRD;
        end else begin
          stateD = S_DONE;
        end
      end
      S_PCRD: begin
        memRd = 1'b1; addrSel = A_ENTRY; stateD = S_PCCAP;
      end
      S_PCCAP: begin
        if (status.rdZero) begin
          stb.setTrap = 1'b1; stb.trapSel = TRAP_UNBOUND;
        end else begin
          stb.ldPc = 1'b1;
        end
        stateD = S_DONE;
      end
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= S_IDLE;
      isProcQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      isProcQ <= isProcD;
    end
  end

  assign busy        = (stateQ != S_IDLE);
  assign resolveDone = (stateQ == S_DONE);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolveDone |=> !resolveDone);

  // R11
  read_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRd |-> busy);

  // R11
  ignore_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !stb.ldStart);

endmodule

// File: rtl/ctrl_link_resolver.sv
module ctrl_link_resolver
  import clr_pkg::*;
#(
  parameter logic [15:0] GFT_BASE     = 16'h0400,
  parameter int          MAX_INDIRECT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] destLink,
  input  logic [15:0] srcLink,
  input  logic        isReturn,
  input  logic [15:0] curGlobal,
  input  logic [31:0] curCode,
  output logic        memRd,
  output logic [15:0] memAddr,
  input  logic [15:0] memRdata,
  output logic        busy,
  output logic        resolveDone,
  output logic [1:0]  trapKind,
  output logic [15:0] trapParam,
  output logic [15:0] newLocal,
  output logic [15:0] newGlobal,
  output logic [31:0] newCode,
  output logic [15:0] newPc
);

  strobe_t   stb;
  addr_sel_e addrSel;
  status_t   status;
  trap_e     trapQ;

  clr_control ctl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .status      (status),
    .stb         (stb),
    .addrSel     (addrSel),
    .memRd       (memRd),
    .busy        (busy),
    .resolveDone (resolveDone)
  );

  clr_datapath #(
    .GFT_BASE     (GFT_BASE),
    .MAX_INDIRECT (MAX_INDIRECT)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .addrSel   (addrSel),
    .busy      (busy),
    .doneIn    (resolveDone),
    .start     (start),
    .destLink  (destLink),
    .srcLink   (srcLink),
    .isReturn  (isReturn),
    .curGlobal (curGlobal),
    .curCode   (curCode),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .status    (status),
    .trapKind  (trapQ),
    .trapParam (trapParam),
    .newLocal  (newLocal),
    .newGlobal (newGlobal),
    .newCode   (newCode),
    .newPc     (newPc)
  );

  assign trapKind = trapQ;

endmodule

// File: tb/ctrl_link_resolver_tb_top.sv
`timescale 1ns/1ps
module ctrl_link_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] destLink = '0, srcLink = '0, curGlobal = '0;
  logic        isReturn = 1'b0;
  logic [31:0] curCode = '0;
  logic        memRd, busy, resolveDone;
  logic [15:0] memAddr, trapParam, newLocal, newGlobal, newPc;
  logic [15:0] memRdata = '0;
  logic [1:0]  trapKind;
  logic [31:0] newCode;

  int checks = 0;
  int failures = 0;
  logic [15:0] mem [0:4095];
  logic [15:0] watchA = 16'hFFFF, watchB = 16'hFFFF;
  int watchHits = 0;

  always #4 clk = ~clk;

  ctrl_link_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .destLink(destLink), .srcLink(srcLink),
    .isReturn(isReturn), .curGlobal(curGlobal), .curCode(curCode), .memRd(memRd),
    .memAddr(memAddr), .memRdata(memRdata), .busy(busy), .resolveDone(resolveDone),
    .trapKind(trapKind), .trapParam(trapParam), .newLocal(newLocal),
    .newGlobal(newGlobal), .newCode(newCode), .newPc(newPc)
  );

  always @(posedge clk) begin
    if (memRd) begin
      memRdata <= mem[memAddr[11:0]];
      if (memAddr == watchA || memAddr == watchB) watchHits++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic launch(input logic [15:0] link, input logic [15:0] src, input logic ret,
                        input logic [15:0] gf, input logic [31:0] cb);
    @(negedge clk);
    destLink = link; srcLink = src; isReturn = ret; curGlobal = gf; curCode = cb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (resolveDone) seen = 1;
      else @(negedge clk);
    end
    chk({req, " done"}, {31'd0, seen}, 32'd1);
  endtask

  task automatic resolve(input string req, input logic [15:0] link, input logic [15:0] src,
                         input logic ret, input logic [15:0] gf, input logic [31:0] cb);
    launch(link, src, ret, gf, cb);
    waitDone(req);
  endtask

  task automatic expectCtx(input string req, input logic [15:0] lf, input logic [15:0] gf,
                           input logic [31:0] cb, input logic [15:0] pc);
    chk({req, " trapKind"}, {30'd0, trapKind}, 32'd0);
    chk({req, " newLocal"}, {16'd0, newLocal}, {16'd0, lf});
    chk({req, " newGlobal"}, {16'd0, newGlobal}, {16'd0, gf});
    chk({req, " newCode"}, newCode, cb);
    chk({req, " newPc"}, {16'd0, newPc}, {16'd0, pc});
  endtask

  task automatic expectTrap(input string req, input logic [1:0] kind, input logic [15:0] param);
    chk({req, " trapKind"}, {30'd0, trapKind}, {30'd0, kind});
    chk({req, " trapParam"}, {16'd0, trapParam}, {16'd0, param});
  endtask

  // R1 R2: frame link with the same global frame
  task automatic testFrameSame();
    watchA = 16'h01FE; watchB = 16'h01FF; watchHits = 0;
    resolve("R1", 16'h0100, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectCtx("R1", 16'h0100, 16'h0200, 32'hDEAD_0300, 16'h0123);
    chk("R2 no code-base reads", watchHits, 0);
    watchA = 16'hFFFF; watchB = 16'hFFFF;
  endtask

  // R3: frame link with a different global frame, then an odd code base
  task automatic testFrameOther();
    resolve("R3", 16'h0110, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectCtx("R3", 16'h0110, 16'h0240, 32'h0001_0800, 16'h0055);
    resolve("R3 code", 16'h0120, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectTrap("R3 code", 2'd3, 16'h0120);
  endtask

  // R4 R5: procedure descriptor with bias 2, link bits [1:0]=11
  task automatic testProc();
    resolve("R4", 16'h0147, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectCtx("R5", 16'h0000, 16'h0300, 32'h0002_0900, 16'h0777);
  endtask

  // R6 R7: unbound causes
  task automatic testUnbound();
    resolve("R6", 16'h0181, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectTrap("R6", 2'd2, 16'h0181);
    resolve("R7", 16'h01C3, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectTrap("R7", 2'd2, 16'h01C3);
  endtask

  // R8: indirect to frame, two-hop indirect to procedure
  task automatic testIndirect();
    resolve("R8 one hop", 16'h0502, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectCtx("R8 one hop", 16'h0100, 16'h0200, 32'hDEAD_0300, 16'h0123);
    resolve("R8 two hops", 16'h0512, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectCtx("R8 two hops", 16'h0000, 16'h0300, 32'h0002_0900, 16'h0777);
  endtask

  // R9: zero links
  task automatic testZero();
    resolve("R9 direct", 16'h0000, 16'h1234, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectTrap("R9 direct", 2'd1, 16'h1234);
    resolve("R9 return", 16'h0000, 16'h1234, 1'b1, 16'h0200, 32'hDEAD_0300);
    expectTrap("R9 return", 2'd1, 16'h0000);
    resolve("R9 via indirect", 16'h0532, 16'h4321, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectTrap("R9 via indirect", 2'd1, 16'h4321);
  endtask

  // R10: exactly eight hops resolve, nine trap
  task automatic testCap();
    resolve("R10 eight", 16'h0602, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectCtx("R10 eight", 16'h0100, 16'h0200, 32'hDEAD_0300, 16'h0123);
    resolve("R10 nine", 16'h05F2, 16'h2222, 1'b0, 16'h0200, 32'hDEAD_0300);
    expectTrap("R10 nine", 2'd1, 16'h2222);
  endtask

  // R11: start ignored while busy, single-cycle done, outputs held
  task automatic testHold();
    launch(16'h0110, 16'h1111, 1'b0, 16'h0200, 32'hDEAD_0300);
    @(negedge clk);
    destLink = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R11");
    expectCtx("R11 busy start ignored", 16'h0110, 16'h0240, 32'h0001_0800, 16'h0055);
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, resolveDone}, 32'd0);
    destLink = 16'h0147; srcLink = 16'h9999; curGlobal = 16'h0000; curCode = 32'h0;
    repeat (4) @(negedge clk);
    expectCtx("R11 held", 16'h0110, 16'h0240, 32'h0001_0800, 16'h0055);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[12'h0FE] = 16'h0200; mem[12'h0FF] = 16'h0123;
    mem[12'h10E] = 16'h0240; mem[12'h10F] = 16'h0055;
    mem[12'h23E] = 16'h0800; mem[12'h23F] = 16'h0001;
    mem[12'h11E] = 16'h0280; mem[12'h11F] = 16'h0066;
    mem[12'h27E] = 16'h0801; mem[12'h27F] = 16'h0000;
    mem[12'h405] = 16'h0302;
    mem[12'h2FE] = 16'h0900; mem[12'h2FF] = 16'h0002;
    mem[12'h945] = 16'h0777;
    mem[12'h406] = 16'h0003;
    mem[12'h407] = 16'h0340;
    mem[12'h33E] = 16'h0A00; mem[12'h33F] = 16'h0000;
    mem[12'h502] = 16'h0100;
    mem[12'h512] = 16'h0522; mem[12'h522] = 16'h0147;
    mem[12'h532] = 16'h0000;
    for (int k = 0; k < 7; k++) mem[12'h602 + 12'(16 * k)] = 16'h0602 + 16'(16 * (k + 1));
    mem[12'h672] = 16'h0100;
    mem[12'h5F2] = 16'h0602;

    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset done", {31'd0, resolveDone}, 32'd0);
    chk("R11 reset memRd", {31'd0, memRd}, 32'd0);
    chk("R9 reset trapKind", {30'd0, trapKind}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    testFrameSame();
    testFrameOther();
    testProc();
    testUnbound();
    testIndirect();
    testZero();
    testCap();
    testHold();
    summary();
  end

endmodule